// File: doc/BRIEF.md
# Receive Lane Polarity Inversion Detector

This block sits on the receive side of a serial link, one detector per lane, after symbol alignment and 8b/10b decoding. While link training runs, each lane watches its own stream for training ordered sets. It checks the identifier symbols of each set. If a whole set carries identifiers that can only come from a swapped differential pair, the lane sets a sticky invert flag. From then on the lane complements the data symbols it passes on. Polarity is corrected only on the receive side, and each lane decides for itself, so one link can have some lanes corrected and others not.

A set opens with a COM control character (0xBC, control flag high), which is position 0. Positions 1 to ID_START-1 are header symbols and are not examined. Positions ID_START to SET_LEN-1 are the identifier field. On a correctly wired pair the identifiers arrive as 0x4A (first training set type) or 0x45 (second type). On a swapped pair they arrive as their complements, 0xB5 or 0xBA. Each lane runs a four-state machine:
- HUNT waits for a COM.
- HEAD counts the header positions.
- IDS checks identifiers.
- SKIP discards the rest of a set that failed.

The transitions are:
- COM_SEEN: a COM in any state goes to HEAD, or straight to IDS when ID_START is 1.
- HEAD_DONE: HEAD goes to IDS after position ID_START-1.
- ID_MISS: IDS goes to SKIP on a symbol that does not match.
- SET_DONE: IDS goes to HUNT on a match at the last position, and sets the flag.
- TRAIN_OFF: any state goes to HUNT while training is inactive.

Top module: `polinv_array`

## Requirements
- R1: After `rst_n` is asserted, every bit of `inv_flag` and `out_vld` is 0.
- R2: During training, a complete set sets that lane's `inv_flag`, one clock after its last symbol is taken, when its identifier positions (ID_START to SET_LEN-1) are all the data value 0xB5 and the set starts with COM (control, 0xBC).
- R3: A complete set whose identifier positions are all the data value 0xBA also sets the lane's flag, including when the symbols are separated by cycles with `sym_vld` low.
- R4: Sets whose identifiers have normal polarity (0x4A or 0x45) never set the flag.
- R5: A set is cancelled by any identifier symbol that is not an inverted identifier, or that differs from the first identifier of the set (0xB5 mixed with 0xBA). A set that a new COM cuts short is also cancelled. Detection restarts at each COM.
- R6: The values at header positions 1 to ID_START-1 do not affect detection.
- R7: While `train_active` is low, no flag is set, even by a complete inverted set.
- R8: Once set, a lane's flag stays set through later normal-polarity sets. It clears only on that lane's `lane_rst` bit or on `rst_n`.
- R9: Each lane detects on its own. Stimulus on one lane never changes another lane's flag, and a lane reset clears only its own lane.
- R10: Output has one cycle of latency. `out_vld` follows `sym_vld`. A data symbol is XORed with 0xFF when the lane's flag is set at the moment the symbol is accepted, and passes unchanged otherwise. Control symbols pass unchanged, with `out_is_k` high.
- R11: Cycles with `sym_vld` low do not advance the symbol position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of all lanes |
| lane_rst | input | LANES | Synchronous per-lane reset, clears that lane's flag and detector |
| train_active | input | 1 | High while link training runs; enables detection |
| sym_vld | input | LANES | Per-lane symbol strobe |
| sym_is_k | input | LANES | Per-lane control-character flag |
| sym_data | input | LANES*8 | Decoded symbols, lane n in bits [8n+7:8n] |
| out_vld | output | LANES | Registered symbol strobe |
| out_is_k | output | LANES | Registered control-character flag |
| out_data | output | LANES*8 | Polarity-corrected symbols |
| inv_flag | output | LANES | Sticky per-lane invert status |

## Verification
The bench builds the block with its defaults: LANES=4, SET_LEN=16 and ID_START=6, so every set has a full ten-symbol identifier field. Four lanes allow several cases on one link at once: one lane left normal, others inverted through different identifier types, and a lane reset while its neighbours stay set. The full-length field places mismatches well inside the set and at its last position. It also lets a set be cut short by a new COM partway through the identifiers.

// File: rtl/polinv_pkg.sv
package polinv_pkg;
    localparam int SYM_W = 8;
    localparam logic [SYM_W-1:0] COM_SYM    = 8'hBC;
    localparam logic [SYM_W-1:0] TS1_ID     = 8'h4A;
    localparam logic [SYM_W-1:0] TS2_ID     = 8'h45;
    localparam logic [SYM_W-1:0] TS1_ID_INV = ~TS1_ID;
    localparam logic [SYM_W-1:0] TS2_ID_INV = ~TS2_ID;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_HEAD,
        ST_IDS,
        ST_SKIP
    } det_state_e;
endpackage

// File: rtl/polinv_lane_det.sv
module polinv_lane_det
    import polinv_pkg::*;
#(
    parameter int SET_LEN  = 16,
    parameter int ID_START = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lane_rst,
    input  logic             train_active,
    input  logic             sym_vld,
    input  logic             sym_is_k,
    input  logic [SYM_W-1:0] sym_data,
    output logic             inv_flag
);
    localparam int CW = $clog2(SET_LEN + 1);
    localparam logic [CW-1:0] LAST_POS = CW'(SET_LEN - 1);
    localparam logic [CW-1:0] HEAD_END = CW'(ID_START - 1);
    localparam logic [CW-1:0] ID_FIRST = CW'(ID_START);
    localparam det_state_e AFTER_COM = (ID_START == 1) ? ST_IDS : ST_HEAD;

    det_state_e    state, state_nx;
    logic [CW-1:0] pos, pos_nx;
    logic          kind, kind_nx;
    logic          set_now;
    logic          is_com, id_hit, id_kind;

    always_comb begin
        is_com   = sym_is_k && (sym_data == COM_SYM);
        id_hit   = !sym_is_k && ((sym_data == TS1_ID_INV) || (sym_data == TS2_ID_INV));
        id_kind  = (sym_data == TS2_ID_INV);
        state_nx = state;
        pos_nx   = pos;
        kind_nx  = kind;
        set_now  = 1'b0;
        if (!train_active) begin
            state_nx = ST_HUNT;                      // TRAIN_OFF
            pos_nx   = '0;
        end else if (sym_vld) begin
            if (is_com) begin
                state_nx = AFTER_COM;                // COM_SEEN
                pos_nx   = CW'(1);
            end else begin
                unique case (state)
                    ST_HUNT, ST_SKIP: begin
                        state_nx = state;
                    end
                    ST_HEAD: begin
                        pos_nx = pos + CW'(1);
                        if (pos == HEAD_END) state_nx = ST_IDS;   // HEAD_DONE
                    end
                    ST_IDS: begin
                        if (!id_hit || ((pos != ID_FIRST) && (id_kind != kind))) begin
                            state_nx = ST_SKIP;      // ID_MISS
                        end else begin
                            kind_nx = id_kind;
                            pos_nx  = pos + CW'(1);
                            if (pos == LAST_POS) begin
                                set_now  = 1'b1;     // SET_DONE
                                state_nx = ST_HUNT;
                            end
                        end
                    end
                    default: state_nx = ST_HUNT;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            pos   <= '0;
            kind  <= 1'b0;
        end else if (lane_rst) begin
            state <= ST_HUNT;
            pos   <= '0;
            kind  <= 1'b0;
        end else begin
            state <= state_nx;
            pos   <= pos_nx;
            kind  <= kind_nx;
        end
    end

    // output: sticky invert flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        inv_flag <= 1'b0;
        else if (lane_rst) inv_flag <= 1'b0;
        else if (set_now)  inv_flag <= 1'b1;
    end
endmodule

// File: rtl/polinv_lane_fix.sv
module polinv_lane_fix
    import polinv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inv_flag,
    input  logic             sym_vld,
    input  logic             sym_is_k,
    input  logic [SYM_W-1:0] sym_data,
    output logic             out_vld,
    output logic             out_is_k,
    output logic [SYM_W-1:0] out_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_is_k <= 1'b0;
            out_data <= '0;
        end else begin
            out_vld <= sym_vld;
            if (sym_vld) begin
                out_is_k <= sym_is_k;
                out_data <= sym_is_k ? sym_data : (sym_data ^ {SYM_W{inv_flag}});
            end
        end
    end
endmodule

// File: rtl/polinv_array.sv
module polinv_array
    import polinv_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int SET_LEN  = 16,
    parameter int ID_START = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [LANES-1:0]       lane_rst,
    input  logic                   train_active,
    input  logic [LANES-1:0]       sym_vld,
    input  logic [LANES-1:0]       sym_is_k,
    input  logic [LANES*SYM_W-1:0] sym_data,
    output logic [LANES-1:0]       out_vld,
    output logic [LANES-1:0]       out_is_k,
    output logic [LANES*SYM_W-1:0] out_data,
    output logic [LANES-1:0]       inv_flag
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        polinv_lane_det #(
            .SET_LEN (SET_LEN),
            .ID_START(ID_START)
        ) u_det (
            .clk         (clk),
            .rst_n       (rst_n),
            .lane_rst    (lane_rst[g]),
            .train_active(train_active),
            .sym_vld     (sym_vld[g]),
            .sym_is_k    (sym_is_k[g]),
            .sym_data    (sym_data[g*SYM_W +: SYM_W]),
            .inv_flag    (inv_flag[g])
        );

        polinv_lane_fix u_fix (
            .clk     (clk),
            .rst_n   (rst_n),
            .inv_flag(inv_flag[g]),
            .sym_vld (sym_vld[g]),
            .sym_is_k(sym_is_k[g]),
            .sym_data(sym_data[g*SYM_W +: SYM_W]),
            .out_vld (out_vld[g]),
            .out_is_k(out_is_k[g]),
            .out_data(out_data[g*SYM_W +: SYM_W])
        );
    end
endmodule

// File: rtl/polinv_chk.sv
module polinv_chk #(
    parameter int LANES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [LANES-1:0]     lane_rst,
    input logic                 train_active,
    input logic [LANES-1:0]     sym_vld,
    input logic [LANES-1:0]     sym_is_k,
    input logic [LANES*8-1:0]   sym_data,
    input logic [LANES-1:0]     out_vld,
    input logic [LANES-1:0]     out_is_k,
    input logic [LANES*8-1:0]   out_data,
    input logic [LANES-1:0]     inv_flag
);
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            inv_flag[g] && !lane_rst[g] |=> inv_flag[g]);

        a_r8_lane_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
            lane_rst[g] |=> !inv_flag[g]);

        a_r7_no_set_off_training: assert property (@(posedge clk) disable iff (!rst_n)
            !train_active && !inv_flag[g] |=> !inv_flag[g]);

        a_r11_no_set_without_symbol: assert property (@(posedge clk) disable iff (!rst_n)
            !sym_vld[g] && !inv_flag[g] |=> !inv_flag[g]);

        a_r10_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
            sym_vld[g] |=> out_vld[g]);

        a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
            !sym_vld[g] |=> !out_vld[g]);

        a_r10_ctrl_passes: assert property (@(posedge clk) disable iff (!rst_n)
            sym_vld[g] && sym_is_k[g] |=>
                out_is_k[g] && (out_data[g*8 +: 8] == $past(sym_data[g*8 +: 8])));

        a_r10_data_corrected: assert property (@(posedge clk) disable iff (!rst_n)
            sym_vld[g] && !sym_is_k[g] |=>
                !out_is_k[g] &&
                (out_data[g*8 +: 8] == ($past(sym_data[g*8 +: 8]) ^ {8{$past(inv_flag[g])}})));
    end
endmodule

bind polinv_array polinv_chk #(.LANES(LANES)) u_polinv_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lane_rst    (lane_rst),
    .train_active(train_active),
    .sym_vld     (sym_vld),
    .sym_is_k    (sym_is_k),
    .sym_data    (sym_data),
    .out_vld     (out_vld),
    .out_is_k    (out_is_k),
    .out_data    (out_data),
    .inv_flag    (inv_flag)
);

// File: tb/test_polinv_array.sv
`timescale 1ns/1ps
module test_polinv_array;
    localparam int LANES    = 4;
    localparam int SET_LEN  = 16;
    localparam int ID_START = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [LANES-1:0]   lane_rst = '0;
    logic               train_active = 1'b0;
    logic [LANES-1:0]   sym_vld = '0;
    logic [LANES-1:0]   sym_is_k = '0;
    logic [LANES*8-1:0] sym_data = '0;
    logic [LANES-1:0]   out_vld;
    logic [LANES-1:0]   out_is_k;
    logic [LANES*8-1:0] out_data;
    logic [LANES-1:0]   inv_flag;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    polinv_array #(
        .LANES(LANES), .SET_LEN(SET_LEN), .ID_START(ID_START)
    ) i_polinv_array (
        .clk(clk), .rst_n(rst_n), .lane_rst(lane_rst), .train_active(train_active),
        .sym_vld(sym_vld), .sym_is_k(sym_is_k), .sym_data(sym_data),
        .out_vld(out_vld), .out_is_k(out_is_k), .out_data(out_data), .inv_flag(inv_flag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic put(input int lane, input bit k, input logic [7:0] d);
        @(negedge clk);
        sym_vld  = '0;
        sym_is_k = '0;
        sym_vld[lane] = 1'b1;
        sym_is_k[lane] = k;
        sym_data[lane*8 +: 8] = d;
    endtask

    task automatic idle();
        @(negedge clk);
        sym_vld  = '0;
        sym_is_k = '0;
    endtask

    // full set; bad_pos < 0 means no substituted identifier
    task automatic send_set(input int lane, input logic [7:0] head, input logic [7:0] id,
                            input int bad_pos, input logic [7:0] bad_val, input bit gap);
        put(lane, 1'b1, 8'hBC);
        for (int p = 1; p < SET_LEN; p++) begin
            if (gap) idle();
            if (p < ID_START)      put(lane, 1'b0, head);
            else if (p == bad_pos) put(lane, 1'b0, bad_val);
            else                   put(lane, 1'b0, id);
        end
        idle();
    endtask

    task automatic chk_flags(input logic [LANES-1:0] exp, input string req);
        chk(inv_flag === exp, req, int'(inv_flag), int'(exp));
    endtask

    task automatic t_reset();
        chk(inv_flag === '0, "R1 flags after reset", int'(inv_flag), 0);
        chk(out_vld === '0, "R1 out_vld after reset", int'(out_vld), 0);
    endtask

    task automatic t_ts1_inverted();
        send_set(0, 8'h20, 8'hB5, -1, 8'h00, 1'b0);
        chk_flags(4'b0001, "R2 inverted TS1 sets lane0 only (R9)");
    endtask

    task automatic t_ts2_inverted_gaps();
        send_set(1, 8'h21, 8'hBA, -1, 8'h00, 1'b1);
        chk_flags(4'b0011, "R3 R11 inverted TS2 with gaps sets lane1");
    endtask

    task automatic t_normal_sets();
        send_set(2, 8'h22, 8'h4A, -1, 8'h00, 1'b0);
        send_set(2, 8'h22, 8'h45, -1, 8'h00, 1'b0);
        chk_flags(4'b0011, "R4 normal sets leave lane2 clear");
    endtask

    task automatic t_mismatch();
        send_set(2, 8'h23, 8'hB5, 10, 8'h4A, 1'b0);
        chk_flags(4'b0011, "R5 mid-field mismatch cancels");
        send_set(2, 8'h23, 8'hB5, SET_LEN - 1, 8'hBA, 1'b0);
        chk_flags(4'b0011, "R5 mixed identifier at last position cancels");
    endtask

    task automatic t_truncated();
        put(2, 1'b1, 8'hBC);
        for (int p = 1; p < ID_START + 3; p++) put(2, 1'b0, (p < ID_START) ? 8'h24 : 8'hB5);
        idle();
        chk_flags(4'b0011, "R5 truncated set does not set");
        send_set(2, 8'h24, 8'hB5, -1, 8'h00, 1'b0);
        chk_flags(4'b0111, "R5 new COM restarts detection");
    endtask

    task automatic t_training_off();
        train_active = 1'b0;
        send_set(3, 8'h25, 8'hBA, -1, 8'h00, 1'b0);
        chk_flags(4'b0111, "R7 no set while training inactive");
        train_active = 1'b1;
    endtask

    task automatic t_header_ignored();
        send_set(3, 8'h4A, 8'hBA, -1, 8'h00, 1'b0);
        chk_flags(4'b1111, "R6 header values ignored");
    endtask

    task automatic t_sticky();
        send_set(0, 8'h26, 8'h4A, -1, 8'h00, 1'b0);
        send_set(0, 8'h26, 8'h45, -1, 8'h00, 1'b0);
        chk_flags(4'b1111, "R8 normal sets keep flag");
        @(negedge clk);
        lane_rst = 4'b0001;
        @(negedge clk);
        lane_rst = '0;
        chk_flags(4'b1110, "R8 R9 lane reset clears own lane only");
    endtask

    task automatic out_case(input int lane, input bit k, input logic [7:0] d,
                            input logic [7:0] exp, input string req);
        put(lane, k, d);
        @(negedge clk);
        chk(out_vld[lane] === 1'b1, req, int'(out_vld[lane]), 1);
        chk(out_is_k[lane] === k, req, int'(out_is_k[lane]), int'(k));
        chk(out_data[lane*8 +: 8] === exp, req, int'(out_data[lane*8 +: 8]), int'(exp));
        sym_vld  = '0;
        sym_is_k = '0;
    endtask

    task automatic t_output();
        out_case(1, 1'b0, 8'h3C, 8'hC3, "R10 data inverted on flagged lane");
        out_case(1, 1'b1, 8'hBC, 8'hBC, "R10 control passes on flagged lane");
        out_case(0, 1'b0, 8'h3C, 8'h3C, "R10 data unchanged on clear lane");
        @(negedge clk);
        chk(out_vld === '0, "R10 out_vld low when idle", int'(out_vld), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        train_active = 1'b1;
        @(negedge clk);
        t_ts1_inverted();
        t_ts2_inverted_gaps();
        t_normal_sets();
        t_mismatch();
        t_truncated();
        t_training_off();
        t_header_ignored();
        t_sticky();
        t_output();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule